// File: doc/BRIEF.md
# Alternating Two-Pattern Bit Sequencer

This block holds two bit patterns, A and B, in on-chip storage and plays them out one bit per clock on a serial output. Pattern A is played from its first bit to its last and repeated a set number of times. Pattern B is then played and repeated its own number of times. The cycle then returns to A and continues without a gap. A marker output shows which pattern the current output bit comes from, so downstream logic or a capture unit can tell the two apart.

Software loads the patterns through a word-wide write port. A single configuration strobe sets both lengths and both repeat counts. A length is given in bits and must be a whole number of 128-bit granules. Settings that fail validation are refused, and an error pulse reports the refusal. Settings that pass are held pending and take effect at the next switch between patterns, so a pattern that is already playing is never cut short. A start strobe restarts playback from the first bit of A and applies any pending settings. Storage depth is a parameter. The default is scaled down for simulation.

Top module: `alt_pattern_seq`

## Requirements
- R1: While rst_ni is low, data_o, sel_b_o and err_o are 0. On the first rising edge after release, data_o carries bit 0 of pattern A and sel_b_o is 0.
- R2: A write with wr_en_i=1 stores wr_data_i into word wr_addr_i of pattern A (wr_bank_i=0) or pattern B (wr_bank_i=1). Bit k of word w is pattern bit WORD_W*w+k. A write takes effect for reads from the next cycle.
- R3: Playback outputs pattern bits 0 to len-1 of A, repeated loop_a times, then bits 0 to len-1 of B, repeated loop_b times. This repeats with one bit per cycle and no idle cycles.
- R4: sel_b_o is 1 exactly while data_o carries a bit of B. It changes in the same cycle as the first bit of the new pattern.
- R5: A cfg_we_i strobe is accepted only when both of these hold. Each length is a multiple of 128 and lies between 128 and PAT_BITS. Each loop count lies between 1 and 127.
- R6: A strobe that fails R5 raises err_o for exactly the next cycle. It changes neither the pending settings nor the active settings.
- R7: Accepted settings become active only at an A-to-B or B-to-A switch, or on start_i. A pattern in progress finishes with its old length and count.
- R8: On an edge where start_i=1, the pending settings become active and data_o and sel_b_o go to 0. The next edge outputs bit 0 of A, on its first repetition.
- R9: After reset, both lengths are 128 and both loop counts are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Pattern word write strobe |
| wr_bank_i | input | 1 | 0 selects pattern A, 1 selects pattern B |
| wr_addr_i | input | 5 | Word address within the pattern |
| wr_data_i | input | 16 | Word to store, bit 0 is played first |
| cfg_we_i | input | 1 | Settings write strobe |
| cfg_len_a_i | input | 10 | Length of A in bits |
| cfg_len_b_i | input | 10 | Length of B in bits |
| cfg_loop_a_i | input | 7 | Repeat count of A |
| cfg_loop_b_i | input | 7 | Repeat count of B |
| start_i | input | 1 | Restart from bit 0 of A |
| data_o | output | 1 | Serial pattern bit |
| sel_b_o | output | 1 | 1 while the bit comes from B |
| err_o | output | 1 | One-cycle pulse on a refused settings write |

## Verification
The assertions check the following on every cycle:
- The playback index stays inside the active length.
- The marker switches only on the first bit of the first repetition.
- A switch follows every final bit of a final repetition.
- The active settings move only on a switch or a start.
- Stored loop counts never become zero.
- A zero loop count always produces an error pulse.

Only the bench's scenarios, compared against a reference model, can show three things: that the bit order and repeat counts match the loaded contents, that a setting written mid-pattern waits for the boundary, and that refused lengths such as 200 or 640 leave playback untouched.

// File: rtl/altseq_pkg.sv
package altseq_pkg;
  localparam int unsigned GRAN_BITS = 128;
  localparam int unsigned LOOP_W    = 7;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/altseq_cfg.sv
module altseq_cfg
  import altseq_pkg::*;
#(
  parameter int unsigned PAT_BITS = 512,
  parameter int unsigned LEN_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [LEN_W-1:0]  len_a_i,
  input  logic [LEN_W-1:0]  len_b_i,
  input  logic [LOOP_W-1:0] loop_a_i,
  input  logic [LOOP_W-1:0] loop_b_i,
  input  logic              apply_i,
  output logic [LEN_W-1:0]  act_len_a_o,
  output logic [LEN_W-1:0]  act_len_b_o,
  output logic [LOOP_W-1:0] act_loop_a_o,
  output logic [LOOP_W-1:0] act_loop_b_o,
  output logic              err_o
);
  localparam int unsigned GRAN_LSB = $clog2(GRAN_BITS);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(GRAN_BITS);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PAT_BITS);

  logic [LEN_W-1:0]  pend_len_a_q, pend_len_b_q;
  logic [LOOP_W-1:0] pend_loop_a_q, pend_loop_b_q;
  logic              len_a_ok, len_b_ok, cfg_ok;

  always_comb begin
    len_a_ok = (len_a_i[GRAN_LSB-1:0] == '0) && (len_a_i >= LEN_MIN) && (len_a_i <= LEN_MAX);
    len_b_ok = (len_b_i[GRAN_LSB-1:0] == '0) && (len_b_i >= LEN_MIN) && (len_b_i <= LEN_MAX);
    cfg_ok   = len_a_ok && len_b_ok && (loop_a_i != '0) && (loop_b_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_len_a_q  <= LEN_MIN;
      pend_len_b_q  <= LEN_MIN;
      pend_loop_a_q <= LOOP_W'(1);
      pend_loop_b_q <= LOOP_W'(1);
      act_len_a_o   <= LEN_MIN;
      act_len_b_o   <= LEN_MIN;
      act_loop_a_o  <= LOOP_W'(1);
      act_loop_b_o  <= LOOP_W'(1);
      err_o         <= 1'b0;
    end else begin
      err_o <= cfg_we_i && !cfg_ok;
      if (cfg_we_i && cfg_ok) begin
        pend_len_a_q  <= len_a_i;
        pend_len_b_q  <= len_b_i;
        pend_loop_a_q <= loop_a_i;
        pend_loop_b_q <= loop_b_i;
      end
      if (apply_i) begin
        act_len_a_o  <= pend_len_a_q;
        act_len_b_o  <= pend_len_b_q;
        act_loop_a_o <= pend_loop_a_q;
        act_loop_b_o <= pend_loop_b_q;
      end
    end
  end

  p_loops_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_loop_a_o != '0) && (act_loop_b_o != '0) && (pend_loop_a_q != '0) && (pend_loop_b_q != '0));

  p_zero_loop_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (loop_a_i == '0 || loop_b_i == '0)) |=> err_o);

  p_apply_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(act_len_a_o) && $stable(act_len_b_o) && $stable(act_loop_a_o) && $stable(act_loop_b_o))
      |-> $past(apply_i));
endmodule

// File: rtl/altseq_mem.sv
module altseq_mem
  import altseq_pkg::*;
#(
  parameter int unsigned PAT_BITS = 512,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned IDX_W    = 9,
  parameter int unsigned AW       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  bank_e             rd_bank_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_bit_o
);
  localparam int unsigned NWORDS = PAT_BITS / WORD_W;
  localparam int unsigned SUB_W  = $clog2(WORD_W);

  logic [WORD_W-1:0] rd_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem_q [NWORDS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NWORDS; i++) mem_q[i] <= '0;
      end else if (wr_en_i && (wr_bank_i == (b == 1))) begin
        mem_q[wr_addr_i] <= wr_data_i;
      end
    end

    assign rd_word[b] = mem_q[rd_idx_i[IDX_W-1:SUB_W]];
  end

  assign rd_bit_o = rd_word[rd_bank_i][rd_idx_i[SUB_W-1:0]];
endmodule

// File: rtl/altseq_ctrl.sv
module altseq_ctrl
  import altseq_pkg::*;
#(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned LEN_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_a_i,
  input  logic [LEN_W-1:0]  len_b_i,
  input  logic [LOOP_W-1:0] loop_a_i,
  input  logic [LOOP_W-1:0] loop_b_i,
  output bank_e             bank_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              boundary_o
);
  bank_e             bank_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LOOP_W-1:0] lp_q;
  logic [LEN_W-1:0]  len_cur;
  logic [LOOP_W-1:0] cnt_cur;
  logic              last_bit, turn;

  always_comb begin
    len_cur  = (bank_q == BANK_B) ? len_b_i : len_a_i;
    cnt_cur  = (bank_q == BANK_B) ? loop_b_i : loop_a_i;
    last_bit = ({1'b0, idx_q} == (len_cur - LEN_W'(1)));
    turn     = last_bit && (lp_q == cnt_cur);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= BANK_A;
      idx_q  <= '0;
      lp_q   <= LOOP_W'(1);
    end else if (start_i) begin
      bank_q <= BANK_A;
      idx_q  <= '0;
      lp_q   <= LOOP_W'(1);
    end else if (last_bit) begin
      idx_q <= '0;
      if (turn) begin
        bank_q <= (bank_q == BANK_A) ? BANK_B : BANK_A;
        lp_q   <= LOOP_W'(1);
      end else begin
        lp_q <= lp_q + LOOP_W'(1);
      end
    end else begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign bank_o     = bank_q;
  assign idx_o      = idx_q;
  assign boundary_o = !start_i && turn;

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, idx_q} < len_cur);

  p_marker_turn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_q != $past(bank_q)) |-> (idx_q == '0) && (lp_q == LOOP_W'(1)));

  p_turn_at_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_o |=> (bank_q != $past(bank_q)));
endmodule

// File: rtl/alt_pattern_seq.sv
module alt_pattern_seq
  import altseq_pkg::*;
#(
  parameter int unsigned PAT_BITS = 512,
  parameter int unsigned WORD_W   = 16,
  localparam int unsigned IDX_W   = $clog2(PAT_BITS),
  localparam int unsigned LEN_W   = IDX_W + 1,
  localparam int unsigned AW      = IDX_W - $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              cfg_we_i,
  input  logic [LEN_W-1:0]  cfg_len_a_i,
  input  logic [LEN_W-1:0]  cfg_len_b_i,
  input  logic [LOOP_W-1:0] cfg_loop_a_i,
  input  logic [LOOP_W-1:0] cfg_loop_b_i,
  input  logic              start_i,
  output logic              data_o,
  output logic              sel_b_o,
  output logic              err_o
);
  logic [LEN_W-1:0]  act_len_a, act_len_b;
  logic [LOOP_W-1:0] act_loop_a, act_loop_b;
  bank_e             bank;
  logic [IDX_W-1:0]  idx;
  logic              boundary, rd_bit;

  altseq_cfg #(.PAT_BITS(PAT_BITS), .LEN_W(LEN_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i,
    .len_a_i(cfg_len_a_i), .len_b_i(cfg_len_b_i),
    .loop_a_i(cfg_loop_a_i), .loop_b_i(cfg_loop_b_i),
    .apply_i(boundary || start_i),
    .act_len_a_o(act_len_a), .act_len_b_o(act_len_b),
    .act_loop_a_o(act_loop_a), .act_loop_b_o(act_loop_b),
    .err_o
  );

  altseq_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .len_a_i(act_len_a), .len_b_i(act_len_b),
    .loop_a_i(act_loop_a), .loop_b_i(act_loop_b),
    .bank_o(bank), .idx_o(idx), .boundary_o(boundary)
  );

  altseq_mem #(.PAT_BITS(PAT_BITS), .WORD_W(WORD_W), .IDX_W(IDX_W), .AW(AW)) u_mem (
    .clk_i, .rst_ni, .wr_en_i, .wr_bank_i, .wr_addr_i, .wr_data_i,
    .rd_bank_i(bank), .rd_idx_i(idx), .rd_bit_o(rd_bit)
  );

  // output stage keeps bit and marker in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= 1'b0;
      sel_b_o <= 1'b0;
    end else if (start_i) begin
      data_o  <= 1'b0;
      sel_b_o <= 1'b0;
    end else begin
      data_o  <= rd_bit;
      sel_b_o <= (bank == BANK_B);
    end
  end

  p_start_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!data_o && !sel_b_o));
endmodule

// File: tb/sim_alt_pattern_seq.sv
module sim_alt_pattern_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 512;
  localparam int WW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_bank = 0, cfg_we = 0, start = 0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [9:0]  len_a = '0, len_b = '0;
  logic [6:0]  loop_a = '0, loop_b = '0;
  logic data_o, sel_b_o, err_o;

  int total = 0, bad = 0;
  string phase = "R1 reset";

  // reference model state
  logic ma [PB];
  logic mb [PB];
  int a_la, a_lb, a_ca, a_cb, p_la, p_lb, p_ca, p_cb;
  int m_bank, m_idx, m_lp;
  logic e_data = 0, e_sel = 0, e_err = 0;

  alt_pattern_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bank_i(wr_bank),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cfg_we_i(cfg_we),
    .cfg_len_a_i(len_a), .cfg_len_b_i(len_b), .cfg_loop_a_i(loop_a),
    .cfg_loop_b_i(loop_b), .start_i(start),
    .data_o(data_o), .sel_b_o(sel_b_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit valid_len(int l);
    return (l % 128 == 0) && l >= 128 && l <= PB;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PB; i++) begin ma[i] = 0; mb[i] = 0; end
      a_la = 128; a_lb = 128; a_ca = 1; a_cb = 1;
      p_la = 128; p_lb = 128; p_ca = 1; p_cb = 1;
      m_bank = 0; m_idx = 0; m_lp = 1;
      e_data = 0; e_sel = 0; e_err = 0;
    end else begin
      int len, cnt;
      bit ok;
      if (start) begin
        a_la = p_la; a_lb = p_lb; a_ca = p_ca; a_cb = p_cb;
        m_bank = 0; m_idx = 0; m_lp = 1; e_data = 0; e_sel = 0;
      end else begin
        e_data = m_bank ? mb[m_idx] : ma[m_idx];
        e_sel  = (m_bank != 0);
        len = m_bank ? a_lb : a_la;
        cnt = m_bank ? a_cb : a_ca;
        if (m_idx == len - 1) begin
          m_idx = 0;
          if (m_lp == cnt) begin
            m_bank = 1 - m_bank; m_lp = 1;
            a_la = p_la; a_lb = p_lb; a_ca = p_ca; a_cb = p_cb;
          end else m_lp++;
        end else m_idx++;
      end
      ok = valid_len(int'(len_a)) && valid_len(int'(len_b)) && loop_a != 0 && loop_b != 0;
      e_err = cfg_we && !ok;
      if (cfg_we && ok) begin
        p_la = int'(len_a); p_lb = int'(len_b); p_ca = int'(loop_a); p_cb = int'(loop_b);
      end
      if (wr_en)
        for (int k = 0; k < WW; k++)
          if (wr_bank) mb[int'(wr_addr)*WW+k] = wr_data[k];
          else         ma[int'(wr_addr)*WW+k] = wr_data[k];
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] t=%0t act=%b exp=%b", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 data", data_o, e_data);
    chk("R4 marker", sel_b_o, e_sel);
    chk("R6 err", err_o, e_err);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(int la, int lb, int ca, int cb);
    @(negedge clk);
    len_a = 10'(la); len_b = 10'(lb); loop_a = 7'(ca); loop_b = 7'(cb); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load(bit bk, int seed);
    for (int w = 0; w < PB/WW; w++) begin
      @(negedge clk);
      wr_en = 1; wr_bank = bk; wr_addr = 5'(w);
      wr_data = 16'((w * 40503 + seed) ^ (w << 7));
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset data", data_o, 1'b0);
    chk("R1 reset marker", sel_b_o, 1'b0);
    chk("R1 reset err", err_o, 1'b0);
    rst_n = 1;
    phase = "R9 defaults, R2 loading";
    load(0, 16'h3C5A);
    load(1, 16'h0F91);
    run(600);
    phase = "R5 R7 accepted mid-pattern";
    run(37);
    set_cfg(256, 128, 2, 3);
    run(1500);
    phase = "R6 zero loop";
    set_cfg(256, 256, 0, 4);
    chk("R6 pulse", err_o, 1'b1);
    run(1);
    chk("R6 pulse one cycle", err_o, 1'b0);
    phase = "R6 bad granule";
    set_cfg(200, 128, 1, 1);
    run(5);
    phase = "R6 over max";
    set_cfg(128, 640, 1, 1);
    run(1200);
    phase = "R5 max length";
    set_cfg(512, 384, 1, 2);
    run(300);
    phase = "R8 start";
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    run(2500);
    phase = "R2 rewrite while playing";
    load(0, 16'h7777);
    run(900);
    phase = "R8 start with pending";
    set_cfg(128, 256, 3, 1);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    run(1200);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule